// File: doc/BRIEF.md
# Dual-Polarity Peak-Current Gate Latch

This block decides when each power-transfer interval of a phase-shifted full-bridge converter must end. It takes a sampled, signed primary-current value and a peak-current reference. It does not rectify the current. Instead it keeps two comparison paths: path A watches the positive current of the first transfer interval, and path B watches the negative current of the second. Each path builds its own threshold. That threshold is the reference with a sign of its own, less a slope-compensation ramp that grows from the start of the interval, plus a shared offset trim. The trim comes from an outside loop that steers the DC primary current toward zero.

The incoming current first passes through a one-pole low-pass filter, which keeps switching ringing from causing false trips. Each path is a small state machine with four states: ST_IDLE (disarmed), ST_BLANK (leading-edge blanking), ST_ARMED (comparing) and ST_DONE (interval ended). The named transitions are: *restart*, on the path's own start strobe, from any state to ST_BLANK, or to ST_ARMED when the blanking length is zero; *unblank*, from ST_BLANK to ST_ARMED once the blanking window has elapsed; *trip*, from ST_ARMED to ST_DONE on a threshold crossing; *timeout*, from ST_BLANK or ST_ARMED to ST_DONE at the maximum interval length; and *disarm*, on the other path's start strobe, from any state to ST_IDLE. The latched commutation request tells the gate timing engine to switch the leading leg.

Top module: `peak_trip_latch`

## Requirements
- R1: After reset, all four outputs (cmt_a, cmt_b, tmo_a, tmo_b) are 0 and both paths are in ST_IDLE.
- R2: The filtered current register updates every cycle as y' = y + ((x - y) >>> FILT_SHIFT). When this step is zero and x > y, the step is +1 instead, so y always reaches x exactly. Comparisons use only y, so a single-cycle spike that y does not carry across the threshold causes no trip.
- R3: The path A threshold is sat(ref - ramp + trim), and A trips when y >= threshold. The path B threshold is sat(-ref + ramp + trim), and B trips when y <= threshold. When a comparison holds in ST_ARMED after clock edge k, the request is set at edge k+1.
- R4: The ramp is 0 at the start edge and grows by `slope` on every later cycle of the interval, saturating at 2^(DW-1)-1. At interval cycle k the ramp equals slope*k.
- R5: A path's commutation request stays set until that path's own start strobe clears it, together with its timeout flag. The other path's start strobe leaves it unchanged.
- R6: A start strobe arms its own path and puts the other path in ST_IDLE, where that path cannot trip. At most one path is armed at any time.
- R7: For the first blank_len cycles after a start edge, comparisons are ignored. With no filter lag and a threshold already exceeded, the request appears blank_len+1 edges after the start edge.
- R8: If no trip occurs, the interval ends at edge max_len after the start edge, and both the request and the timeout flag are set. A trip in the same cycle wins and leaves the timeout flag at 0.
- R9: Each threshold sum saturates at -2^(DW-1) or 2^(DW-1)-1 and never wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_pri | input | DW | Sampled primary current, signed |
| pk_ref | input | DW | Peak-current reference, signed |
| slope | input | DW-1 | Ramp increment per cycle, unsigned |
| trim | input | DW | Offset-correction term added to both thresholds, signed |
| blank_len | input | CW | Leading-edge blanking length, in cycles |
| max_len | input | CW | Maximum interval length, in cycles (at least 1) |
| start_a | input | 1 | Start strobe for the first transfer interval (path A) |
| start_b | input | 1 | Start strobe for the second transfer interval (path B) |
| cmt_a | output | 1 | Latched commutation request from path A |
| cmt_b | output | 1 | Latched commutation request from path B |
| tmo_a | output | 1 | Path A ended its interval by timeout |
| tmo_b | output | 1 | Path B ended its interval by timeout |

## Verification
The assertions take for granted that start_a and start_b never pulse in the same cycle, that max_len is at least 1, and that reference, slope, trim and interval limits do not change during an interval. The single-armed-path property and the restart properties depend on these assumptions. The directed stimulus pulses one strobe at a time, and it changes configuration only between intervals, after the current has settled through the filter. Whether a request came from a trip or a timeout is judged from the cycle counts that R3, R7 and R8 predict.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BLANK,
        ST_ARMED,
        ST_DONE
    } ptl_state_e;

endpackage

// File: rtl/ptl_filter.sv
module ptl_filter #(
    parameter int DW = 16,
    parameter int FILT_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] y
);
    localparam logic signed [DW:0] STEP_ONE = 1;

    logic signed [DW:0] diff;
    logic signed [DW:0] step;
    logic signed [DW:0] nxt;

    always_comb begin
        diff = {x[DW-1], x} - {y[DW-1], y};
        step = diff >>> FILT_SHIFT;
        if (step == 0 && diff > 0) begin
            step = STEP_ONE;
        end
        nxt = {y[DW-1], y} + step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y <= '0;
        end else begin
            y <= nxt[DW-1:0];
        end
    end

    // R2: the filtered value moves toward a larger input
    p_filt_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (x > y) |=> (y > $past(y)));
    // R2: a settled filter stays put
    p_filt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (x == y) |=> $stable(y));

endmodule

// File: rtl/ptl_threshold.sv
module ptl_threshold #(
    parameter int DW  = 16,
    parameter bit NEG = 1'b0
) (
    input  logic signed [DW-1:0] ref_in,
    input  logic        [DW-2:0] ramp,
    input  logic signed [DW-1:0] trim,
    input  logic signed [DW-1:0] cur,
    output logic signed [DW-1:0] thr,
    output logic                 hit
);
    localparam int WW = DW + 2;
    localparam logic signed [WW-1:0] LIM_HI = (WW'(1) <<< (DW - 1)) - WW'(1);
    localparam logic signed [WW-1:0] LIM_LO = -(WW'(1) <<< (DW - 1));

    logic signed [WW-1:0] ref_w;
    logic signed [WW-1:0] ramp_w;
    logic signed [WW-1:0] trim_w;
    logic signed [WW-1:0] sum;

    always_comb begin
        ref_w  = {{2{ref_in[DW-1]}}, ref_in};
        ramp_w = {3'b000, ramp};
        trim_w = {{2{trim[DW-1]}}, trim};
        if (NEG) begin
            sum = -ref_w + ramp_w + trim_w;
        end else begin
            sum = ref_w - ramp_w + trim_w;
        end
        if (sum > LIM_HI) begin
            thr = LIM_HI[DW-1:0];
        end else if (sum < LIM_LO) begin
            thr = LIM_LO[DW-1:0];
        end else begin
            thr = sum[DW-1:0];
        end
    end

    generate
        if (NEG) begin : g_neg
            assign hit = (cur <= thr);
        end else begin : g_pos
            assign hit = (cur >= thr);
        end
    endgenerate

endmodule

// File: rtl/ptl_path.sv
module ptl_path
    import ptl_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_own,
    input  logic          start_other,
    input  logic [CW-1:0] blank_len,
    input  logic [CW-1:0] max_len,
    input  logic [DW-2:0] slope,
    input  logic          hit,
    output logic          armed,
    output logic [DW-2:0] ramp,
    output logic          cmt,
    output logic          tmo
);
    localparam logic [CW-1:0] ONE = 1;

    ptl_state_e    st;
    ptl_state_e    st_nxt;
    logic [CW-1:0] el;
    logic          set_trip;
    logic          set_to;
    logic [DW-1:0] ramp_sum;

    always_comb begin
        st_nxt   = st;
        set_trip = 1'b0;
        set_to   = 1'b0;
        if (start_own) begin
            st_nxt = (blank_len == '0) ? ST_ARMED : ST_BLANK;
        end else if (start_other) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: st_nxt = ST_IDLE;
                ST_BLANK: begin
                    if (el == max_len - ONE) begin
                        st_nxt = ST_DONE;
                        set_to = 1'b1;
                    end else if (el == blank_len - ONE) begin
                        st_nxt = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (hit) begin
                        st_nxt   = ST_DONE;
                        set_trip = 1'b1;
                    end else if (el == max_len - ONE) begin
                        st_nxt = ST_DONE;
                        set_to = 1'b1;
                    end
                end
                ST_DONE: st_nxt = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    assign ramp_sum = {1'b0, ramp} + {1'b0, slope};
    assign armed    = (st == ST_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            el   <= '0;
            ramp <= '0;
            cmt  <= 1'b0;
            tmo  <= 1'b0;
        end else if (start_own) begin
            el   <= '0;
            ramp <= '0;
            cmt  <= 1'b0;
            tmo  <= 1'b0;
        end else begin
            if (st == ST_BLANK || st == ST_ARMED) begin
                el   <= el + ONE;
                ramp <= ramp_sum[DW-1] ? '1 : ramp_sum[DW-2:0];
            end
            if (set_trip) begin
                cmt <= 1'b1;
            end
            if (set_to) begin
                cmt <= 1'b1;
                tmo <= 1'b1;
            end
        end
    end

    // R5: the request holds until the path's own start strobe
    p_cmt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt && !start_own) |=> cmt);
    // R5: the own start strobe clears both flags
    p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_own |=> (!cmt && !tmo));
    // R4: the ramp restarts from zero
    p_ramp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_own |=> (ramp == '0));
    // R6: the other path's strobe disarms this path
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_other && !start_own) |=> (st == ST_IDLE));
    // R7: a trip is only taken from the armed state
    p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmt) && !tmo) |-> ($past(st) == ST_ARMED));
    // R8: a timeout always comes with a request
    p_tmo_cmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> cmt);

endmodule

// File: rtl/peak_trip_latch.sv
module peak_trip_latch #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int FILT_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] i_pri,
    input  logic signed [DW-1:0] pk_ref,
    input  logic        [DW-2:0] slope,
    input  logic signed [DW-1:0] trim,
    input  logic        [CW-1:0] blank_len,
    input  logic        [CW-1:0] max_len,
    input  logic                 start_a,
    input  logic                 start_b,
    output logic                 cmt_a,
    output logic                 cmt_b,
    output logic                 tmo_a,
    output logic                 tmo_b
);
    localparam int NPATH = 2;

    logic signed [DW-1:0] i_filt;
    logic [NPATH-1:0]     start_v;
    logic [NPATH-1:0]     armed_v;
    logic [NPATH-1:0]     hit_v;
    logic [NPATH-1:0]     cmt_v;
    logic [NPATH-1:0]     tmo_v;
    logic [DW-2:0]        ramp_v [NPATH];
    logic signed [DW-1:0] thr_v  [NPATH];

    assign start_v = {start_b, start_a};

    ptl_filter #(.DW(DW), .FILT_SHIFT(FILT_SHIFT)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (i_pri),
        .y     (i_filt)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        ptl_threshold #(.DW(DW), .NEG((g == 1) ? 1'b1 : 1'b0)) u_thr (
            .ref_in (pk_ref),
            .ramp   (ramp_v[g]),
            .trim   (trim),
            .cur    (i_filt),
            .thr    (thr_v[g]),
            .hit    (hit_v[g])
        );

        ptl_path #(.DW(DW), .CW(CW)) u_path (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_own   (start_v[g]),
            .start_other (start_v[NPATH-1-g]),
            .blank_len   (blank_len),
            .max_len     (max_len),
            .slope       (slope),
            .hit         (hit_v[g]),
            .armed       (armed_v[g]),
            .ramp        (ramp_v[g]),
            .cmt         (cmt_v[g]),
            .tmo         (tmo_v[g])
        );
    end

    assign cmt_a = cmt_v[0];
    assign cmt_b = cmt_v[1];
    assign tmo_a = tmo_v[0];
    assign tmo_b = tmo_v[1];

    // R6: never both paths armed
    p_single_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(armed_v) <= 1);
    // R9: non-negative inputs with no ramp cannot wrap path A negative
    p_nowrap_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_ref >= 0 && trim >= 0 && ramp_v[0] == '0) |-> (thr_v[0] >= 0));
    // R9: path B with non-negative reference and non-positive trim stays non-positive
    p_nowrap_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_ref >= 0 && trim <= 0 && ramp_v[1] == '0) |-> (thr_v[1] <= 0));

endmodule

// File: tb/peak_trip_latch_test.sv
`timescale 1ns/1ps
module peak_trip_latch_test;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int FS = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] i_pri = '0;
    logic signed [DW-1:0] pk_ref = '0;
    logic        [DW-2:0] slope = '0;
    logic signed [DW-1:0] trim = '0;
    logic        [CW-1:0] blank_len = '0;
    logic        [CW-1:0] max_len = 16'd200;
    logic                 start_a = 1'b0;
    logic                 start_b = 1'b0;
    logic                 cmt_a, cmt_b, tmo_a, tmo_b;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    peak_trip_latch #(.DW(DW), .CW(CW), .FILT_SHIFT(FS)) uut (
        .clk(clk), .rst_n(rst_n), .i_pri(i_pri), .pk_ref(pk_ref), .slope(slope),
        .trim(trim), .blank_len(blank_len), .max_len(max_len),
        .start_a(start_a), .start_b(start_b),
        .cmt_a(cmt_a), .cmt_b(cmt_b), .tmo_a(tmo_a), .tmo_b(tmo_b)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic settle(input int x);
        i_pri = DW'(x);
        repeat (60) @(negedge clk);
    endtask

    task automatic pulse(input int path);
        if (path == 0) start_a = 1'b1; else start_b = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_a = 1'b0;
        start_b = 1'b0;
    endtask

    task automatic count_to(input int path, output int n);
        n = 0;
        while (((path == 0) ? cmt_a : cmt_b) == 1'b0 && n < 400) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int fstep(input int y, input int x);
        int d, s;
        d = x - y;
        s = d >>> FS;
        if (s == 0 && d > 0) s = 1;
        return y + s;
    endfunction

    task automatic t_reset();
        check("R1 cmt_a", cmt_a, 0);
        check("R1 cmt_b", cmt_b, 0);
        check("R1 tmo_a", tmo_a, 0);
        check("R1 tmo_b", tmo_b, 0);
    endtask

    task automatic t_slope();
        int n;
        pk_ref = 100; slope = 10; trim = 0; blank_len = 0; max_len = 200;
        settle(50);
        pulse(0);
        count_to(0, n);
        check("R4 ramp trip A edge", n, 6);
        check("R3 no timeout A", tmo_a, 0);
        settle(-50);
        pulse(1);
        count_to(1, n);
        check("R4 ramp trip B edge", n, 6);
        check("R5 A kept after B start", cmt_a, 1);
    endtask

    task automatic t_hold_arm();
        pk_ref = 100; slope = 0;
        settle(0);
        check("R5 B held", cmt_b, 1);
        pulse(0);
        check("R5 A cleared by own start", cmt_a, 0);
        pulse(1);
        check("R5 B cleared by own start", cmt_b, 0);
        settle(500);
        check("R6 A disarmed", cmt_a, 0);
        check("R6 B not tripped", cmt_b, 0);
    endtask

    task automatic t_blank();
        int n;
        pk_ref = 10; slope = 0; blank_len = 4;
        settle(50);
        pulse(0);
        count_to(0, n);
        check("R7 blanked trip edge", n, 5);
        blank_len = 0;
        pulse(0);
        count_to(0, n);
        check("R7 unblanked trip edge", n, 1);
    endtask

    task automatic t_timeout();
        int n;
        pk_ref = 1000; blank_len = 2; max_len = 20;
        settle(0);
        pulse(0);
        count_to(0, n);
        check("R8 timeout edge", n, 20);
        check("R8 timeout flag", tmo_a, 1);
        blank_len = 0; max_len = 200;
    endtask

    task automatic t_trim();
        int n;
        pk_ref = 100; trim = -30;
        settle(80);
        pulse(0);
        count_to(0, n);
        check("R3 trim lowers A", n, 1);
        settle(-110);
        pulse(1);
        repeat (40) @(negedge clk);
        check("R3 trim shifts B", cmt_b, 0);
        trim = 0;
    endtask

    task automatic t_filter();
        int n, y, k;
        pk_ref = 60;
        settle(0);
        pulse(0);
        y = 0; k = 0;
        while (y < 60) begin
            y = fstep(y, 100);
            k++;
        end
        i_pri = 100;
        count_to(0, n);
        check("R2 filtered trip edge", n, k + 1);
        settle(0);
        pulse(0);
        i_pri = 100;
        @(negedge clk);
        i_pri = 0;
        repeat (20) @(negedge clk);
        check("R2 spike rejected", cmt_a, 0);
    endtask

    task automatic t_sat();
        pk_ref = 16'sd32767; trim = 10;
        settle(-5);
        pulse(0);
        repeat (20) @(negedge clk);
        check("R9 A saturates high", cmt_a, 0);
        trim = -10;
        settle(5);
        pulse(1);
        repeat (20) @(negedge clk);
        check("R9 B saturates low", cmt_b, 0);
        trim = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slope();
        t_hold_arm();
        t_blank();
        t_timeout();
        t_trim();
        t_filter();
        t_sat();
        summary();
        $finish;
    end

endmodule